// File: doc/BRIEF.md
# USB Host Subsystem Configuration Register Block

This block holds the configuration state of a USB host subsystem and serves it through three memory windows that share one 32-bit read/write bus. One window covers the transceiver link layer (4 KB). One covers host-level configuration (1 KB). The third is a 1 KB window for vendor-specific EHCI extensions, and it holds a single ULPI control register. A separate select picks each window. In any cycle the bus master asserts at most one select, together with a read or write enable, a byte offset and an access size.

Read data comes from a register, one cycle after the access. An error flag is also registered and pulses for one cycle after an access the block rejects: an access narrower than 32 bits, a write to a read-only or unmapped offset in the host or link window, or a read of an unmapped host offset. A write that sets the soft-reset bit of the host sysconfig register returns every host and link register to its reset value. The reset wins over the value just written. The ULPI register is cleared only by the hardware reset. The two interrupt outputs are held inactive.

Top module: `usbh_cfg_regs`

## Requirements
- R1: After the synchronous reset, host sysconfig reads 0x1, host config reads 0x700, debug CSR reads 0x20, link sysconfig reads 0x1 and the ULPI register reads 0. rdata and err are 0.
- R2: A 32-bit read (size 2'b10) with one select asserted returns its data on rdata in the cycle after the access. In any cycle after one with no such read, rdata is 0.
- R3: In the host window, offset 0x00 reads 0x10 and offset 0x14 reads 0x7. Writes to either offset leave them unchanged and raise err.
- R4: Host sysconfig (offset 0x10) stores the written value ANDed with 0x311D. Host config (0x40) uses mask 0x1F3D and debug CSR (0x44) uses mask 0xF00FF. A register changes only on a write to its own offset or on a reset.
- R5: A 32-bit write to host offset 0x10 with bit 1 set returns host sysconfig, host config, debug CSR and link sysconfig to their R1 values. This also applies to the register being written.
- R6: In the link window, offsets 0x00 and 0x14 read 0x1, and offsets 0x18 and 0x1C read 0. Link sysconfig (0x10) stores the write ANDed with 0xFFFFFEE0.
- R7: In the vendor window, offset 0xA4 keeps bits [31:28] of a write. Every other offset reads 0, ignores writes and raises no error. A soft reset leaves the ULPI register unchanged, while the hardware reset clears it.
- R8: The access size is 2'b00 byte, 2'b01 half-word or 2'b10 word. Any size other than 2'b10 returns 0 on a read and has no effect on a write. It raises err in the next cycle.
- R9: err is high for the single cycle after a write to a read-only or unmapped offset in the host or link window, or after a read of an unmapped host offset. Unmapped link reads return 0 without err.
- R10: irq_link and irq_ehci are always 0.
- R11: The host and vendor windows decode only address bits [9:0]. The link window decodes all 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_link | input | 1 | Selects the link-layer window |
| sel_host | input | 1 | Selects the host configuration window |
| sel_vnd | input | 1 | Selects the vendor EHCI window |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| addr | input | ADDR_W (12) | Byte offset within the selected window |
| wdata | input | 32 | Write data |
| size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Registered rejected-access pulse |
| irq_link | output | 1 | Link-layer interrupt, held low |
| irq_ehci | output | 1 | EHCI interrupt, held low |

## Verification
The bench builds the block with its default ADDR_W of 12. This width reaches every offset of the 4 KB link window and lets addresses above 0x3FF hit the 1 KB windows. An access at 0x440 then shows that only the low ten bits are decoded. With the masks and reset values left at their defaults, the bench writes all-ones patterns and sees exactly the stated mask values. It then follows a soft reset that overrides its own write, while the ULPI register holds its value until a hardware reset clears it.

// File: rtl/usbh_cfg_pkg.sv
package usbh_cfg_pkg;
  localparam int DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // host window offsets and values
  localparam logic [11:0] H_ID_OFF   = 12'h000;
  localparam logic [11:0] H_SYS_OFF  = 12'h010;
  localparam logic [11:0] H_STAT_OFF = 12'h014;
  localparam logic [11:0] H_CFG_OFF  = 12'h040;
  localparam logic [11:0] H_DBG_OFF  = 12'h044;
  localparam logic [DW-1:0] H_ID_VAL   = 32'h10;
  localparam logic [DW-1:0] H_STAT_VAL = 32'h7;
  localparam logic [DW-1:0] H_SYS_MASK = 32'h0000_311D;
  localparam logic [DW-1:0] H_SYS_RST  = 32'h1;
  localparam logic [DW-1:0] H_CFG_MASK = 32'h0000_1F3D;
  localparam logic [DW-1:0] H_CFG_RST  = 32'h700;
  localparam logic [DW-1:0] H_DBG_MASK = 32'h000F_00FF;
  localparam logic [DW-1:0] H_DBG_RST  = 32'h20;
  localparam int            SOFT_BIT   = 1;

  // link window offsets and values
  localparam logic [11:0] L_ID_OFF   = 12'h000;
  localparam logic [11:0] L_SYS_OFF  = 12'h010;
  localparam logic [11:0] L_STAT_OFF = 12'h014;
  localparam logic [11:0] L_IST_OFF  = 12'h018;
  localparam logic [11:0] L_IEN_OFF  = 12'h01C;
  localparam logic [DW-1:0] L_ID_VAL   = 32'h1;
  localparam logic [DW-1:0] L_STAT_VAL = 32'h1;
  localparam logic [DW-1:0] L_SYS_MASK = 32'hFFFF_FEE0;
  localparam logic [DW-1:0] L_SYS_RST  = 32'h1;

  // vendor window
  localparam logic [11:0]   V_ULPI_OFF  = 12'h0A4;
  localparam logic [DW-1:0] V_ULPI_MASK = 32'hF000_0000;
  localparam logic [DW-1:0] V_ULPI_RST  = 32'h0;
endpackage

// File: rtl/usbh_mreg.sv
module usbh_mreg #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  MASK = '1,
  parameter logic [W-1:0]  RSTV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // clear has priority over a write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr) q <= RSTV;
    else if (we)    q <= d & MASK;
  end

  AST_HOLD_UNLESS_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (!we && !clr) |=> $stable(q)); // R4
endmodule

// File: rtl/usbh_host_win.sv
module usbh_host_win
  import usbh_cfg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rval,
  output logic          bad,
  output logic          soft_rst
);
  logic hit_id, hit_sys, hit_stat, hit_cfg, hit_dbg, hit_ro, mapped;
  logic [DW-1:0] sys_q, cfg_q, dbg_q;

  assign hit_id   = (off == H_ID_OFF[AW-1:0]);
  assign hit_sys  = (off == H_SYS_OFF[AW-1:0]);
  assign hit_stat = (off == H_STAT_OFF[AW-1:0]);
  assign hit_cfg  = (off == H_CFG_OFF[AW-1:0]);
  assign hit_dbg  = (off == H_DBG_OFF[AW-1:0]);
  assign hit_ro   = hit_id | hit_stat;
  assign mapped   = hit_ro | hit_sys | hit_cfg | hit_dbg;

  assign soft_rst = wr & hit_sys & wdata[SOFT_BIT];

  usbh_mreg #(.W(DW), .MASK(H_SYS_MASK), .RSTV(H_SYS_RST)) u_sys (
    .clk(clk), .rst(rst), .clr(soft_rst), .we(wr & hit_sys), .d(wdata), .q(sys_q));
  usbh_mreg #(.W(DW), .MASK(H_CFG_MASK), .RSTV(H_CFG_RST)) u_cfg (
    .clk(clk), .rst(rst), .clr(soft_rst), .we(wr & hit_cfg), .d(wdata), .q(cfg_q));
  usbh_mreg #(.W(DW), .MASK(H_DBG_MASK), .RSTV(H_DBG_RST)) u_dbg (
    .clk(clk), .rst(rst), .clr(soft_rst), .we(wr & hit_dbg), .d(wdata), .q(dbg_q));

  always_comb begin
    rval = '0;
    if (hit_id)   rval = H_ID_VAL;
    if (hit_sys)  rval = sys_q;
    if (hit_stat) rval = H_STAT_VAL;
    if (hit_cfg)  rval = cfg_q;
    if (hit_dbg)  rval = dbg_q;
  end

  assign bad = (wr & (hit_ro | ~mapped)) | (rd & ~mapped);

  AST_SOFT_OVERRIDES_WRITE: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (sys_q == H_SYS_RST && cfg_q == H_CFG_RST)); // R5
endmodule

// File: rtl/usbh_link_win.sv
module usbh_link_win
  import usbh_cfg_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          wr,
  input  logic [AW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rval,
  output logic          bad
);
  logic hit_sys;
  logic [DW-1:0] sys_q;

  assign hit_sys = (off == L_SYS_OFF[AW-1:0]);

  usbh_mreg #(.W(DW), .MASK(L_SYS_MASK), .RSTV(L_SYS_RST)) u_sys (
    .clk(clk), .rst(rst), .clr(soft_rst), .we(wr & hit_sys), .d(wdata), .q(sys_q));

  always_comb begin
    rval = '0;
    if (off == L_ID_OFF[AW-1:0])   rval = L_ID_VAL;
    if (hit_sys)                   rval = sys_q;
    if (off == L_STAT_OFF[AW-1:0]) rval = L_STAT_VAL;
    // interrupt status and enable read as zero
  end

  // only sysconfig is writable; every other write is rejected
  assign bad = wr & ~hit_sys;

  AST_LINK_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (sys_q == L_SYS_RST)); // R5
endmodule

// File: rtl/usbh_vnd_win.sv
module usbh_vnd_win
  import usbh_cfg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          wr,
  input  logic [AW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rval
);
  logic hit;
  logic [DW-1:0] ulpi_q;

  assign hit = (off == V_ULPI_OFF[AW-1:0]);

  // hardware reset only: soft reset does not reach this register
  usbh_mreg #(.W(DW), .MASK(V_ULPI_MASK), .RSTV(V_ULPI_RST)) u_ulpi (
    .clk(clk), .rst(rst), .clr(1'b0), .we(wr & hit), .d(wdata), .q(ulpi_q));

  assign rval = hit ? ulpi_q : '0;

  AST_ULPI_SURVIVES_SOFT: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !(wr && hit)) |=> $stable(ulpi_q)); // R7
endmodule

// File: rtl/usbh_cfg_regs.sv
module usbh_cfg_regs
  import usbh_cfg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SMALL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_link,
  input  logic              sel_host,
  input  logic              sel_vnd,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [1:0]        size,
  output logic [DW-1:0]     rdata,
  output logic              err,
  output logic              irq_link,
  output logic              irq_ehci
);
  logic word, any_sel, acc_any, rd_ok, wr_ok;
  logic host_bad, link_bad, soft_rst;
  logic [DW-1:0] host_rv, link_rv, vnd_rv, rd_mux;

  assign word    = (size == SZ_WORD);
  assign any_sel = sel_link | sel_host | sel_vnd;
  assign acc_any = any_sel & (rd_en | wr_en);
  assign rd_ok   = rd_en & word;
  assign wr_ok   = wr_en & word;

  usbh_host_win #(.AW(SMALL_W)) u_host (
    .clk(clk), .rst(rst), .wr(sel_host & wr_ok), .rd(sel_host & rd_ok),
    .off(addr[SMALL_W-1:0]), .wdata(wdata), .rval(host_rv), .bad(host_bad),
    .soft_rst(soft_rst));

  usbh_link_win #(.AW(ADDR_W)) u_link (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr(sel_link & wr_ok),
    .off(addr), .wdata(wdata), .rval(link_rv), .bad(link_bad));

  usbh_vnd_win #(.AW(SMALL_W)) u_vnd (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr(sel_vnd & wr_ok),
    .off(addr[SMALL_W-1:0]), .wdata(wdata), .rval(vnd_rv));

  always_comb begin
    rd_mux = '0;
    if (sel_host)      rd_mux = host_rv;
    else if (sel_link) rd_mux = link_rv;
    else if (sel_vnd)  rd_mux = vnd_rv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= (rd_ok & any_sel) ? rd_mux : '0;
      err   <= (acc_any & ~word) | host_bad | link_bad;
    end
  end

  assign irq_link = 1'b0;
  assign irq_ehci = 1'b0;

  AST_NARROW_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (acc_any && !word) |=> err); // R8
  AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && any_sel && !word) |=> (rdata == '0)); // R8
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(rd_ok && any_sel) |=> (rdata == '0)); // R2
  AST_SELECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_link, sel_host, sel_vnd})); // R2
endmodule

// File: tb/usbh_cfg_regs_test.sv
module usbh_cfg_regs_test;
  localparam logic [2:0] WL = 3'b001, WH = 3'b010, WV = 3'b100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic sel_link = 0, sel_host = 0, sel_vnd = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = 2'b10;
  logic [31:0] rdata;
  logic err, irq_link, irq_ehci;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  usbh_cfg_regs uut (
    .clk(clk), .rst(rst), .sel_link(sel_link), .sel_host(sel_host), .sel_vnd(sel_vnd),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .size(size),
    .rdata(rdata), .err(err), .irq_link(irq_link), .irq_ehci(irq_ehci));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] win, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [1:0] sz,
                        output logic [31:0] rv, output logic ev);
    @(negedge clk);
    sel_link = win[0]; sel_host = win[1]; sel_vnd = win[2];
    wr_en = w; rd_en = !w; addr = a; wdata = d; size = sz;
    @(negedge clk);
    rv = rdata; ev = err;
    sel_link = 0; sel_host = 0; sel_vnd = 0; wr_en = 0; rd_en = 0;
    size = 2'b10;
    check("R10 irq", {30'b0, irq_link, irq_ehci}, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] win, input logic [11:0] a,
                        input logic [31:0] exp, input logic exp_err);
    logic [31:0] rv; logic ev;
    access(win, 1'b0, a, 32'h0, 2'b10, rv, ev);
    check(req, rv, exp);
    check({req, " err"}, {31'b0, ev}, {31'b0, exp_err});
  endtask

  task automatic wr_chk(input string req, input logic [2:0] win, input logic [11:0] a,
                        input logic [31:0] d, input logic [1:0] sz, input logic exp_err);
    logic [31:0] rv; logic ev;
    access(win, 1'b1, a, d, sz, rv, ev);
    check({req, " err"}, {31'b0, ev}, {31'b0, exp_err});
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 32'h0);
    check("R1 err", {31'b0, err}, 32'h0);
    rd_chk("R1 host sys", WH, 12'h010, 32'h1, 0);
    rd_chk("R1 host cfg", WH, 12'h040, 32'h700, 0);
    rd_chk("R1 host dbg", WH, 12'h044, 32'h20, 0);
    rd_chk("R1 link sys", WL, 12'h010, 32'h1, 0);
    rd_chk("R1 ulpi", WV, 12'h0A4, 32'h0, 0);
  endtask

  task automatic t_constants;
    rd_chk("R3 host id", WH, 12'h000, 32'h10, 0);
    rd_chk("R3 host stat", WH, 12'h014, 32'h7, 0);
    rd_chk("R6 link id", WL, 12'h000, 32'h1, 0);
    rd_chk("R6 link stat", WL, 12'h014, 32'h1, 0);
    rd_chk("R6 link irq status", WL, 12'h018, 32'h0, 0);
    rd_chk("R6 link irq enable", WL, 12'h01C, 32'h0, 0);
  endtask

  task automatic t_masks;
    wr_chk("R4 cfg write", WH, 12'h040, 32'hFFFF_FFFF, 2'b10, 0);
    rd_chk("R4 cfg mask", WH, 12'h040, 32'h0000_1F3D, 0);
    wr_chk("R4 dbg write", WH, 12'h044, 32'hFFFF_FFFF, 2'b10, 0);
    rd_chk("R4 dbg mask", WH, 12'h044, 32'h000F_00FF, 0);
    wr_chk("R4 sys write", WH, 12'h010, 32'hFFFF_FFFD, 2'b10, 0);
    rd_chk("R4 sys mask", WH, 12'h010, 32'h0000_311D, 0);
    rd_chk("R4 cfg untouched", WH, 12'h040, 32'h0000_1F3D, 0);
    wr_chk("R6 link sys write", WL, 12'h010, 32'hFFFF_FFFF, 2'b10, 0);
    rd_chk("R6 link sys mask", WL, 12'h010, 32'hFFFF_FEE0, 0);
    wr_chk("R7 ulpi write", WV, 12'h0A4, 32'hFFFF_FFFF, 2'b10, 0);
    rd_chk("R7 ulpi mask", WV, 12'h0A4, 32'hF000_0000, 0);
    rd_chk("R11 host alias", WH, 12'h440, 32'h0000_1F3D, 0);
  endtask

  task automatic t_idle;
    rd_chk("R2 read", WH, 12'h044, 32'h000F_00FF, 0);
    @(negedge clk);
    check("R2 idle rdata", rdata, 32'h0);
  endtask

  task automatic t_rejects;
    wr_chk("R3 write id", WH, 12'h000, 32'hDEAD_BEEF, 2'b10, 1);
    rd_chk("R3 id kept", WH, 12'h000, 32'h10, 0);
    wr_chk("R3 write stat", WH, 12'h014, 32'h0, 2'b10, 1);
    rd_chk("R3 stat kept", WH, 12'h014, 32'h7, 0);
    wr_chk("R9 host unmapped wr", WH, 12'h020, 32'h1234_5678, 2'b10, 1);
    rd_chk("R9 host unmapped rd", WH, 12'h020, 32'h0, 1);
    @(negedge clk);
    check("R9 err one cycle", {31'b0, err}, 32'h0);
    wr_chk("R9 link ro wr", WL, 12'h014, 32'hFFFF_FFFF, 2'b10, 1);
    wr_chk("R9 link irq wr", WL, 12'h018, 32'hFFFF_FFFF, 2'b10, 1);
    rd_chk("R9 link unmapped rd", WL, 12'h800, 32'h0, 0);
    rd_chk("R11 link full decode", WL, 12'h410, 32'h0, 0);
    wr_chk("R7 vnd other wr", WV, 12'h010, 32'hFFFF_FFFF, 2'b10, 0);
    rd_chk("R7 vnd other rd", WV, 12'h010, 32'h0, 0);
    rd_chk("R7 ulpi kept", WV, 12'h0A4, 32'hF000_0000, 0);
  endtask

  task automatic t_narrow;
    logic [31:0] rv; logic ev;
    wr_chk("R8 half write", WH, 12'h040, 32'h0, 2'b01, 1);
    rd_chk("R8 half write no effect", WH, 12'h040, 32'h0000_1F3D, 0);
    wr_chk("R8 byte write soft", WH, 12'h010, 32'h2, 2'b00, 1);
    rd_chk("R8 no soft reset", WH, 12'h044, 32'h000F_00FF, 0);
    access(WH, 1'b0, 12'h040, 32'h0, 2'b00, rv, ev);
    check("R8 byte read data", rv, 32'h0);
    check("R8 byte read err", {31'b0, ev}, 32'h1);
    access(WL, 1'b0, 12'h000, 32'h0, 2'b11, rv, ev);
    check("R8 size3 read data", rv, 32'h0);
    check("R8 size3 read err", {31'b0, ev}, 32'h1);
  endtask

  task automatic t_soft;
    wr_chk("R5 soft write", WH, 12'h010, 32'h0000_311F, 2'b10, 0);
    rd_chk("R5 sys reset wins", WH, 12'h010, 32'h1, 0);
    rd_chk("R5 cfg reset", WH, 12'h040, 32'h700, 0);
    rd_chk("R5 dbg reset", WH, 12'h044, 32'h20, 0);
    rd_chk("R5 link sys reset", WL, 12'h010, 32'h1, 0);
    rd_chk("R7 ulpi survives soft", WV, 12'h0A4, 32'hF000_0000, 0);
  endtask

  task automatic t_hard;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd_chk("R7 ulpi hard clear", WV, 12'h0A4, 32'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_constants();
    t_masks();
    t_idle();
    t_rejects();
    t_narrow();
    t_soft();
    t_hard();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule